// File: doc/BRIEF.md
# Single-Multiplier FIR Filter with Circular Sample Store

This block is an N-tap FIR filter that does all of its arithmetic with one multiplier and one accumulator. It computes y(n) = sum over i from 0 to N-1 of h(i)·x(n-i). Samples and coefficients share one dual-port memory that reads after write. Slots 0 to N-1 hold the sample history as a circular buffer, reached through port A. Slots N to 2N-1 hold the taps, reached through port B, which only reads. The block produces both address streams, the sample write enable and the strobes that clear the accumulator and capture the result.

An output period lasts N+1 fast clock cycles. In the first cycle of a period, the newest sample is written into the current write slot. The same cycle reads that slot back through the read-after-write path and pairs it with h(0). The next N-1 cycles walk backwards through older samples while port B steps up through h(1)..h(N-1). The last cycle is a stall: port A repeats the slot where the next sample will land, and nothing is accumulated. The write slot therefore moves forward by one slot per period. The taps are loaded through a side port, which also works while reset is held. Reset clears only the sample history, not the taps.

Top module: `mac_fir`

## Requirements
- R1: In the first cycle after reset is released, `yValid` is 0, `yOut` is 0 and `sampleTake` is 1.
- R2: `sampleTake` is high for exactly one cycle in every N+1 cycles. The value on `sampleIn` in that cycle is the sample accepted for the period.
- R3: Each result equals sum over i of h(i)·x(n-i), where x(n) is the most recently accepted sample. Samples and taps are two's complement. The result is full precision in `ACC_W` bits.
- R4: `yValid` is a one-cycle pulse. The result for x(n) is flagged N+2 cycles after the cycle in which x(n) was accepted.
- R5: `yOut` changes only in cycles where `yValid` is high, and holds its value between pulses.
- R6: The sample accepted in a period contributes to that period's result. The first result after reset with an impulse of amplitude A is A·h(0).
- R7: After reset all history slots read as zero. An impulse of amplitude A as the first sample after reset gives results A·h(k) for k = 0..N-1, followed by zeros.
- R8: When `coefWe` is high, `coefData` becomes tap h(`coefIdx`) for `coefIdx` < N. This works while reset is asserted, and taps survive a later reset.
- R9: The sample write happens at the slot that port A presented in the stall cycle just before it. Port B steps by one through the tap region from its first address, N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | SMP_W | Signed sample offered to the filter |
| sampleTake | output | 1 | High in the cycle where `sampleIn` is accepted |
| coefWe | input | 1 | Tap write strobe |
| coefIdx | input | $clog2(TAPS) | Tap index to write |
| coefData | input | COEF_W | Signed tap value |
| yOut | output | ACC_W | Signed filter result, held between updates |
| yValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Assertions guard the cycle-level mechanics on every clock:
- the read-after-write return of port A;
- the single-cycle sample strobe;
- the write landing on the stalled slot;
- the stepping of the tap address;
- the single-cycle result strobe;
- the holding of `yOut` between strobes.

Whether the address walk actually pairs each sample with the right tap can only be shown by the bench's scenarios, which compare every result with a full convolution. The same holds for whether reset really empties the history and whether taps survive a reset. Those scenarios use random data, full-scale extremes and impulses.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;
  // strobes from the sequencer to the arithmetic pipeline
  typedef struct packed {
    logic tap;    // this cycle carries a sample/tap pair
    logic first;  // pair for h(0): restart the sum
    logic last;   // pair for h(N-1): capture the sum
  } mac_strobe_t;
endpackage

// File: rtl/mac_fir_mem.sv
module mac_fir_mem #(
  parameter int N      = 92,
  parameter int SMP_W  = 8,
  parameter int COEF_W = 12,
  parameter int AW     = 7,
  parameter int BW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     aAddr,
  input  logic              aWe,
  input  logic [SMP_W-1:0]  aWrData,
  output logic [SMP_W-1:0]  aRdData,
  input  logic [BW-1:0]     bAddr,
  output logic [COEF_W-1:0] bRdData,
  input  logic              ldWe,
  input  logic [AW-1:0]     ldIdx,
  input  logic [COEF_W-1:0] ldData
);
  localparam int WORD_W = (SMP_W > COEF_W) ? SMP_W : COEF_W;
  localparam int DEPTH  = 2 * N;

  logic [WORD_W-1:0] store [DEPTH];
  logic [BW-1:0]     aIdx;
  logic [BW-1:0]     ldSlot;
  logic [WORD_W-1:0] aWord;
  logic [WORD_W-1:0] ldWord;
  logic              ldHit;

  assign aIdx   = BW'(aAddr);
  assign ldSlot = BW'(N) + BW'(ldIdx);
  assign aWord  = WORD_W'(aWrData);
  assign ldWord = WORD_W'(ldData);
  assign ldHit  = ldWe && (32'(ldIdx) < N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) store[i] <= '0;
      aRdData <= '0;
      bRdData <= '0;
    end else begin
      if (aWe) store[aIdx] <= aWord;
      // read-after-write: a same-cycle write is returned on the read port
      aRdData <= aWe ? aWrData : store[aIdx][SMP_W-1:0];
      bRdData <= store[bAddr][COEF_W-1:0];
    end
    if (ldHit) store[ldSlot] <= ldWord;
  end

  // R6: written data comes back on the next cycle's read output
  a_r6_raw_return: assert property (@(posedge clk) disable iff (!rst_n)
    aWe |=> aRdData == $past(aWrData));
endmodule

// File: rtl/mac_fir_ctrl.sv
module mac_fir_ctrl
  import mac_fir_pkg::*;
#(
  parameter int N   = 92,
  parameter int AW  = 7,
  parameter int BW  = 8,
  parameter int PHW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] aAddr,
  output logic          aWe,
  output logic [BW-1:0] bAddr,
  output mac_strobe_t   strobe
);
  localparam logic [PHW-1:0] PH_STALL = PHW'(N);
  localparam logic [PHW-1:0] PH_LAST  = PHW'(N - 1);
  localparam logic [AW-1:0]  SLOT_TOP = AW'(N - 1);
  localparam logic [BW-1:0]  B_BASE   = BW'(N);
  localparam logic [BW-1:0]  B_TOP    = BW'(2 * N - 1);

  logic [PHW-1:0] phase;
  logic [AW-1:0]  slotPtr;
  logic [AW-1:0]  slotPrev;

  assign slotPrev = (slotPtr == '0) ? SLOT_TOP : slotPtr - 1'b1;

  // phase 0: write+read newest slot; 1..N-1: older slots; N: stall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      slotPtr <= '0;
    end else if (phase == PH_STALL) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase != PH_LAST) slotPtr <= slotPrev;
    end
  end

  always_comb begin
    aAddr        = slotPtr;
    aWe          = (phase == '0);
    bAddr        = (phase == PH_STALL) ? B_TOP : B_BASE + BW'(phase);
    strobe.tap   = (phase != PH_STALL);
    strobe.first = (phase == '0);
    strobe.last  = (phase == PH_LAST);
  end

  // R2: the sample strobe never lasts two cycles
  a_r2_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    aWe |=> !aWe);
  // R2: a stall cycle is always followed by a period start
  a_r2_stall_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.tap |=> aWe);
  // R9: the write lands on the slot held during the preceding stall
  a_r9_write_at_stall: assert property (@(posedge clk) disable iff (!rst_n)
    aWe |-> aAddr == $past(aAddr));
  // R9: tap address either restarts at the region base or steps by one
  a_r9_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bAddr) |-> (bAddr == B_BASE || bAddr == $past(bAddr) + 1'b1));
endmodule

// File: rtl/mac_fir_datapath.sv
module mac_fir_datapath
  import mac_fir_pkg::*;
#(
  parameter int SMP_W  = 8,
  parameter int COEF_W = 12,
  parameter int PROD_W = 20,
  parameter int ACC_W  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_strobe_t       strobeIn,
  input  logic [SMP_W-1:0]  smpWord,
  input  logic [COEF_W-1:0] coefWord,
  output logic [ACC_W-1:0]  yOut,
  output logic              yValid
);
  // stage 1 aligns with memory read data, stage 2 with the product register
  mac_strobe_t              s1, s2;
  logic signed [PROD_W-1:0] smpExt, coefExt, prod;
  logic signed [ACC_W-1:0]  acc, accNext, prodExt;

  assign smpExt  = {{(PROD_W-SMP_W){smpWord[SMP_W-1]}}, smpWord};
  assign coefExt = {{(PROD_W-COEF_W){coefWord[COEF_W-1]}}, coefWord};
  assign prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign accNext = (s2.first ? '0 : acc) + prodExt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      prod   <= '0;
      acc    <= '0;
      yOut   <= '0;
      yValid <= 1'b0;
    end else begin
      s1     <= strobeIn;
      s2     <= s1;
      prod   <= smpExt * coefExt;
      yValid <= 1'b0;
      if (s2.tap) acc <= accNext;
      if (s2.tap && s2.last) begin
        yOut   <= accNext;
        yValid <= 1'b1;
      end
    end
  end

  // R4: result strobe is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    yValid |=> !yValid);
  // R5: the result register moves only together with its strobe
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(yOut) |-> yValid);
  // R3: a capture is preceded by a restart N-1 pairs earlier; at least the
  // capture cycle itself must be a tap cycle two stages back
  a_r3_capture_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yValid) |-> $past(s1.last, 2) || $past(s2.last));
endmodule

// File: rtl/mac_fir.sv
module mac_fir
  import mac_fir_pkg::*;
#(
  parameter int TAPS   = 92,
  parameter int SMP_W  = 8,
  parameter int COEF_W = 12,
  parameter int PROD_W = 20,
  parameter int ACC_W  = 27,
  localparam int AW    = $clog2(TAPS),
  localparam int BW    = $clog2(2 * TAPS),
  localparam int PHW   = $clog2(TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SMP_W-1:0]  sampleIn,
  output logic              sampleTake,
  input  logic              coefWe,
  input  logic [AW-1:0]     coefIdx,
  input  logic [COEF_W-1:0] coefData,
  output logic [ACC_W-1:0]  yOut,
  output logic              yValid
);
  logic [AW-1:0]     aAddr;
  logic              aWe;
  logic [BW-1:0]     bAddr;
  mac_strobe_t       strobe;
  logic [SMP_W-1:0]  smpRd;
  logic [COEF_W-1:0] coefRd;

  assign sampleTake = aWe;

  mac_fir_ctrl #(.N(TAPS), .AW(AW), .BW(BW), .PHW(PHW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .aAddr(aAddr), .aWe(aWe), .bAddr(bAddr),
    .strobe(strobe)
  );

  mac_fir_mem #(.N(TAPS), .SMP_W(SMP_W), .COEF_W(COEF_W), .AW(AW), .BW(BW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .aAddr(aAddr), .aWe(aWe), .aWrData(sampleIn), .aRdData(smpRd),
    .bAddr(bAddr), .bRdData(coefRd),
    .ldWe(coefWe), .ldIdx(coefIdx), .ldData(coefData)
  );

  mac_fir_datapath #(.SMP_W(SMP_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobeIn(strobe), .smpWord(smpRd),
    .coefWord(coefRd), .yOut(yOut), .yValid(yValid)
  );
endmodule

// File: tb/mac_fir_tb.sv
`timescale 1ns/1ps
module mac_fir_tb;
  localparam int N  = 92;
  localparam int SW = 8;
  localparam int CW = 12;
  localparam int AW = 7;
  localparam int YW = 27;
  localparam int IMP = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          coefWe = 1'b0;
  logic [AW-1:0] coefIdx = '0;
  logic [CW-1:0] coefData = '0;
  logic          sampleTake, yValid;
  logic [YW-1:0] yOut;

  always #2 clk = ~clk;

  mac_fir u_dut (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .sampleTake(sampleTake),
    .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .yOut(yOut), .yValid(yValid)
  );

  int checks = 0, failures = 0;
  int hModel [N];
  int xHist  [N];
  int expQ [$];
  longint dueQ [$];
  longint cyc = 0, lastTake = -1;
  bit yMoved = 0;
  logic [YW-1:0] prevY = '0;
  int takeCount = 0, outSinceRst = 0, mode = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int convolve();
    int s = 0;
    for (int i = 0; i < N; i++) s += hModel[i] * xHist[i];
    return s;
  endfunction

  // monitor: samples away from the active edge
  always @(negedge clk) begin : mon
    int e;
    longint d;
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) xHist[i] = 0;
      expQ.delete(); dueQ.delete();
      lastTake = -1; yMoved = 0; takeCount = 0; outSinceRst = 0;
    end else begin
      if (!yValid && yOut != prevY) yMoved = 1;
      if (yValid) begin
        if (expQ.size() == 0) chk(0, "R4 strobe without pending result", 1, 0);
        else begin
          e = expQ.pop_front();
          d = dueQ.pop_front();
          chk($signed(yOut) == e, "R3 convolution value", longint'($signed(yOut)), e);
          chk(cyc == d, "R4 result latency", cyc, d);
          chk(!yMoved, "R5 output held between strobes", yMoved, 0);
          if (mode == 2 && outSinceRst == 0)
            chk($signed(yOut) == IMP * hModel[0], "R6 newest sample in own period",
                longint'($signed(yOut)), IMP * hModel[0]);
          if (mode == 2 && outSinceRst > 0 && outSinceRst < N + 2)
            chk($signed(yOut) == ((outSinceRst < N) ? IMP * hModel[outSinceRst] : 0),
                "R7 empty history after reset", longint'($signed(yOut)),
                (outSinceRst < N) ? IMP * hModel[outSinceRst] : 0);
        end
        yMoved = 0;
        outSinceRst++;
      end
      if (sampleTake) begin
        if (lastTake >= 0) chk(cyc - lastTake == N + 1, "R2 take period", cyc - lastTake, N + 1);
        lastTake = cyc;
        for (int i = N - 1; i > 0; i--) xHist[i] = xHist[i - 1];
        xHist[0] = int'($signed(sampleIn));
        takeCount++;
        expQ.push_back(convolve());
        dueQ.push_back(cyc + N + 2);
      end
    end
    prevY = yOut;
  end

  // stimulus driver: changes inputs just after the active edge
  initial begin
    forever begin
      @(posedge clk); #1;
      case (mode)
        0: sampleIn = SW'($urandom);
        1: sampleIn = ($urandom_range(0, 1) != 0) ? 8'h7F : 8'h80;
        2: sampleIn = (takeCount == 0) ? SW'(IMP) : '0;
        default: sampleIn = 8'h80;
      endcase
    end
  end

  // R8: tap load through the side port, here while reset is held
  task automatic loadTaps(input int kind);
    for (int i = 0; i < N; i++) begin
      hModel[i] = (kind == 0) ? int'($urandom_range(0, 4095)) - 2048 : -2048;
      @(posedge clk); #1;
      coefWe = 1'b1; coefIdx = AW'(i); coefData = CW'(hModel[i]);
    end
    @(posedge clk); #1;
    coefWe = 1'b0;
  endtask

  task automatic doReset(input bit load, input int kind, input int newMode);
    @(posedge clk); #1;
    rst_n = 1'b0;
    if (load) loadTaps(kind);
    repeat (3) @(posedge clk);
    #1;
    mode = newMode;
    rst_n = 1'b1;
    @(negedge clk);
    chk(yValid == 1'b0, "R1 reset yValid", yValid, 0);
    chk(yOut == '0, "R1 reset yOut", yOut, 0);
    chk(sampleTake == 1'b1, "R1 reset sampleTake", sampleTake, 1);
  endtask

  task automatic waitOutputs(input int n);
    while (outSinceRst < n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    doReset(1, 0, 0);          // random taps, random samples
    waitOutputs(40);
    mode = 1;                   // full-scale alternating extremes
    waitOutputs(70);
    doReset(0, 0, 2);          // R8: taps kept across reset; impulse
    waitOutputs(N + 4);
    doReset(1, 1, 3);          // all taps -2048, all samples -128
    waitOutputs(N + 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule